// File: doc/BRIEF.md
# Peripheral Processor Protection and Trap Unit

This block sits between a small peripheral processor core with a 12-bit address space and that core's local memory. It gives the core two privilege modes, user and monitor. A boundary register splits memory in two. Words below the boundary are shared by both modes. Words at or above it belong to the monitor. In monitor mode, references to the 64 direct cells at the bottom of memory are moved to the top page, so monitor code has a private set of direct cells. Indexed and indirect references are never moved, so the monitor can still reach the user's cells.

In user mode, the unit watches for three kinds of trouble: an illegal operation, an external event, and a deliberate call from the user program. An illegal operation is an access to protected memory or an I/O instruction. When any of these appears, the unit redirects the core in the same cycle with a return jump. The interrupted address is written to the word at the boundary, execution resumes at the boundary plus one, and the unit switches to monitor mode. A status register records what caused the entry. The core's datapath lies outside this block.

Top module: `pp_guard`

## Requirements
- R1: After reset the unit is in monitor mode, the status reads zero, no redirect is requested, and the boundary holds its reset value (octal 4000 by default).
- R2: In monitor mode, an access flagged as a direct-cell reference is sent to octal 7700 plus its low six address bits. An access without the flag passes through unchanged.
- R3: In user mode, every address passes through unchanged, whether or not the direct-cell flag is set.
- R4: An access below the boundary is allowed in both modes. An access at or above the boundary is allowed in monitor mode and refused (acc_ok low) in user mode.
- R5: In user mode, a refused access or an I/O instruction raises a redirect in the same cycle. During that cycle, redir_target is the boundary plus one and save_we is high, with save_addr set to the boundary and save_data set to pc_in. From the next cycle the unit is in monitor mode with status bit 0 (illegal operation) set.
- R6: An external event line that is high in user mode causes the same redirect. The following status shows bit 1 set and the line(s) recorded in status bits 3 and up (event line n at bit 3+n).
- R7: A user call request in user mode causes the redirect and sets status bit 2.
- R8: While in monitor mode, external events never redirect; they are held pending. The first user-mode cycle after a return then takes the redirect, and the held lines appear in status.
- R9: A return request in monitor mode switches to user mode on the next cycle and clears the whole status. A return request in user mode is ignored.
- R10: The boundary can be written only in monitor mode. A write attempted in user mode leaves the protection limit unchanged.
- R11: When several causes coincide in one user cycle, all of their status bits are recorded together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Core presents a memory access this cycle |
| acc_addr | input | 12 | Effective address of the access |
| acc_direct | input | 1 | Access is a direct-cell (non-indexed, non-indirect) reference |
| io_instr | input | 1 | Core is issuing an I/O instruction |
| evt_in | input | 4 | External event lines |
| user_call | input | 1 | Explicit monitor call from the running program |
| ret_req | input | 1 | Monitor requests the return to user mode |
| pc_in | input | 12 | Address to save on a redirect |
| bnd_we | input | 1 | Boundary write strobe |
| bnd_wdata | input | 12 | New boundary value |
| mem_addr | output | 12 | Address sent to local memory |
| acc_ok | output | 1 | Access is permitted |
| redir_valid | output | 1 | Return jump taken this cycle |
| redir_target | output | 12 | Next fetch address on a redirect |
| save_we | output | 1 | Write the saved address to memory |
| save_addr | output | 12 | Location of the saved address |
| save_data | output | 12 | Saved address value |
| mode_mon | output | 1 | High in monitor mode |
| status | output | 7 | Bits 0..2: illegal, external, call; bits 3..6: captured event lines |

## Verification
A wrong mode bit shows up within one cycle: direct-cell addresses are remapped or not remapped by mistake, and accesses at or above the boundary are wrongly granted or refused. A corrupted boundary shifts both the permission edge and the redirect target in every later cycle. A lost pending event only becomes visible at the first user cycle after a return, as a missing redirect. The reference model is therefore compared on every clock, across long random runs in which modes change often.

// File: rtl/pp_guard_pkg.sv
package pp_guard_pkg;
   localparam int CAUSE_ILL  = 0;
   localparam int CAUSE_EXT  = 1;
   localparam int CAUSE_CALL = 2;
   localparam int CAUSE_W    = 3;

   typedef enum logic {
      MODE_USER = 1'b0,
      MODE_MON  = 1'b1
   } pp_mode_e;
endpackage

// File: rtl/pp_guard_remap.sv
module pp_guard_remap #(
   parameter int AW       = 12,
   parameter int DCW      = 6,
   parameter bit REMAP_EN = 1'b1
) (
   input  logic          mon,
   input  logic          direct,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out
);
   localparam int TOPW = AW - DCW;

   if (DCW < 1 || DCW >= AW) begin : g_bad_dcw
      $error("pp_guard_remap: DCW must lie between 1 and AW-1");
   end

   generate
      if (REMAP_EN) begin : g_remap
         always_comb begin
            if (mon && direct)
               addr_out = {{TOPW{1'b1}}, addr_in[DCW-1:0]};
            else
               addr_out = addr_in;
         end
      end else begin : g_pass
         assign addr_out = addr_in;
      end
   endgenerate
endmodule

// File: rtl/pp_guard_bound.sv
module pp_guard_bound #(
   parameter int AW      = 12,
   parameter int BND_RST = 2048
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mon,
   input  logic          we,
   input  logic [AW-1:0] wdata,
   input  logic          acc_valid,
   input  logic [AW-1:0] acc_addr,
   output logic [AW-1:0] bnd,
   output logic          above,
   output logic          acc_ok
);
   localparam logic [AW-1:0] RST_VAL = AW'(BND_RST);

   if (BND_RST < 0 || BND_RST >= (1 << AW)) begin : g_bad_rst
      $error("pp_guard_bound: BND_RST does not fit in AW bits");
   end

   logic [AW-1:0] bnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bnd_q <= RST_VAL;
      else if (we && mon)
         bnd_q <= wdata;
   end

   assign bnd    = bnd_q;
   assign above  = (acc_addr >= bnd_q);
   assign acc_ok = acc_valid && (mon || !above);

   // R10: boundary is frozen while in user mode
   p_bnd_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mon |=> $stable(bnd_q));
endmodule

// File: rtl/pp_guard_trap.sv
module pp_guard_trap
   import pp_guard_pkg::*;
#(
   parameter int AW   = 12,
   parameter int NEVT = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ill,
   input  logic [NEVT-1:0]         evt_in,
   input  logic                    call,
   input  logic                    ret,
   input  logic [AW-1:0]           pc_in,
   input  logic [AW-1:0]           bnd,
   output logic                    mon,
   output logic                    redir_valid,
   output logic [AW-1:0]           redir_target,
   output logic                    save_we,
   output logic [AW-1:0]           save_addr,
   output logic [AW-1:0]           save_data,
   output logic [CAUSE_W+NEVT-1:0] status
);
   localparam int SW = CAUSE_W + NEVT;

   if (NEVT < 1) begin : g_bad_nevt
      $error("pp_guard_trap: NEVT must be at least 1");
   end

   pp_mode_e        mode_q;
   logic [NEVT-1:0] pend_q;
   logic [SW-1:0]   stat_q;
   logic [NEVT-1:0] evt_all;
   logic            user;
   logic            trap;
   logic [CAUSE_W-1:0] cause;

   assign user    = (mode_q == MODE_USER);
   assign evt_all = pend_q | evt_in;
   assign trap    = user && (ill || (|evt_all) || call);

   always_comb begin
      cause             = '0;
      cause[CAUSE_ILL]  = ill;
      cause[CAUSE_EXT]  = |evt_all;
      cause[CAUSE_CALL] = call;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_MON;
         pend_q <= '0;
         stat_q <= '0;
      end else if (trap) begin
         mode_q <= MODE_MON;
         pend_q <= '0;
         stat_q <= {evt_all, cause};
      end else if (mode_q == MODE_MON) begin
         pend_q <= evt_all;
         if (ret) begin
            mode_q <= MODE_USER;
            stat_q <= '0;
         end
      end
   end

   assign mon          = (mode_q == MODE_MON);
   assign redir_valid  = trap;
   assign redir_target = bnd + 1'b1;
   assign save_we      = trap;
   assign save_addr    = bnd;
   assign save_data    = pc_in;
   assign status       = stat_q;

   // R5: a redirect always lands in monitor mode
   p_trap_to_mon_r5: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> mon);
   // R8: no redirect is ever taken in monitor mode
   p_mon_no_redir_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mon |-> !redir_valid);
   // R9: a return clears status and leaves monitor mode
   p_ret_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mon && ret) |=> (!mon && status == '0));
   // R5: any redirect records at least one cause
   p_cause_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (status[CAUSE_W-1:0] != '0));
endmodule

// File: rtl/pp_guard.sv
module pp_guard
   import pp_guard_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DCW      = 6,
   parameter int NEVT     = 4,
   parameter int BND_RST  = 2048,
   parameter bit REMAP_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_valid,
   input  logic [AW-1:0]           acc_addr,
   input  logic                    acc_direct,
   input  logic                    io_instr,
   input  logic [NEVT-1:0]         evt_in,
   input  logic                    user_call,
   input  logic                    ret_req,
   input  logic [AW-1:0]           pc_in,
   input  logic                    bnd_we,
   input  logic [AW-1:0]           bnd_wdata,
   output logic [AW-1:0]           mem_addr,
   output logic                    acc_ok,
   output logic                    redir_valid,
   output logic [AW-1:0]           redir_target,
   output logic                    save_we,
   output logic [AW-1:0]           save_addr,
   output logic [AW-1:0]           save_data,
   output logic                    mode_mon,
   output logic [CAUSE_W+NEVT-1:0] status
);
   logic          mon;
   logic [AW-1:0] bnd;
   logic          above;
   logic          ill;

   pp_guard_remap #(.AW(AW), .DCW(DCW), .REMAP_EN(REMAP_EN)) u_remap (
      .mon      (mon),
      .direct   (acc_direct),
      .addr_in  (acc_addr),
      .addr_out (mem_addr)
   );

   pp_guard_bound #(.AW(AW), .BND_RST(BND_RST)) u_bound (
      .clk       (clk),
      .rst_n     (rst_n),
      .mon       (mon),
      .we        (bnd_we),
      .wdata     (bnd_wdata),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .bnd       (bnd),
      .above     (above),
      .acc_ok    (acc_ok)
   );

   assign ill = (acc_valid && above) || io_instr;

   pp_guard_trap #(.AW(AW), .NEVT(NEVT)) u_trap (
      .clk          (clk),
      .rst_n        (rst_n),
      .ill          (ill),
      .evt_in       (evt_in),
      .call         (user_call),
      .ret          (ret_req),
      .pc_in        (pc_in),
      .bnd          (bnd),
      .mon          (mon),
      .redir_valid  (redir_valid),
      .redir_target (redir_target),
      .save_we      (save_we),
      .save_addr    (save_addr),
      .save_data    (save_data),
      .status       (status)
   );

   assign mode_mon = mon;

   // R3: user mode never moves an address
   p_user_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_mon |-> (mem_addr == acc_addr));
   // R4: protected words are refused to user accesses
   p_user_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !mode_mon && acc_addr >= bnd) |-> (!acc_ok && redir_valid));
   // R2: remapped direct cells land on the top page
   generate
      if (REMAP_EN) begin : g_chk_remap
         p_mon_top_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_mon && acc_direct) |-> (&mem_addr[AW-1:DCW]));
      end
   endgenerate
endmodule

// File: tb/pp_guard_test.sv
module pp_guard_test;
   localparam int AW = 12;
   localparam int NEVT = 4;
   localparam int SW = 3 + NEVT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 0, acc_direct = 0, io_instr = 0, user_call = 0, ret_req = 0, bnd_we = 0;
   logic [AW-1:0] acc_addr = '0, pc_in = '0, bnd_wdata = '0;
   logic [NEVT-1:0] evt_in = '0;
   logic [AW-1:0] mem_addr, redir_target, save_addr, save_data;
   logic acc_ok, redir_valid, save_we, mode_mon;
   logic [SW-1:0] status;

   int tests = 0;
   int fails = 0;

   // reference model state
   bit m_mon;
   int m_bnd;
   int m_pend;
   int m_stat;

   always #5 clk = ~clk;

   pp_guard uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_direct(acc_direct), .io_instr(io_instr), .evt_in(evt_in),
      .user_call(user_call), .ret_req(ret_req), .pc_in(pc_in),
      .bnd_we(bnd_we), .bnd_wdata(bnd_wdata), .mem_addr(mem_addr),
      .acc_ok(acc_ok), .redir_valid(redir_valid), .redir_target(redir_target),
      .save_we(save_we), .save_addr(save_addr), .save_data(save_data),
      .mode_mon(mode_mon), .status(status)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      acc_valid = 0; acc_direct = 0; io_instr = 0; user_call = 0;
      ret_req = 0; bnd_we = 0; evt_in = '0; acc_addr = '0;
      bnd_wdata = '0; pc_in = '0;
   endtask

   // compare every output with the model, then clock both
   task automatic adv();
      int ill, eall, trap, e_addr, e_ok;
      #1;
      ill  = ((acc_valid && acc_addr >= m_bnd) || io_instr) ? 1 : 0;
      eall = m_pend | evt_in;
      trap = (!m_mon && (ill != 0 || eall != 0 || user_call)) ? 1 : 0;
      e_addr = (m_mon && acc_direct) ? ('o7700 | (acc_addr & 'o77)) : acc_addr;
      e_ok = (acc_valid && (m_mon || acc_addr < m_bnd)) ? 1 : 0;
      chk("R2/R3 mem_addr", mem_addr, e_addr);
      chk("R4 acc_ok", acc_ok, e_ok);
      chk("R5/R8 redir_valid", redir_valid, trap);
      chk("R5 save_we", save_we, trap);
      if (trap != 0) begin
         chk("R5 redir_target", redir_target, (m_bnd + 1) % 4096);
         chk("R5 save_addr", save_addr, m_bnd);
         chk("R5 save_data", save_data, pc_in);
      end
      chk("R9 mode_mon", mode_mon, m_mon);
      chk("R6/R7/R11 status", status, m_stat);
      if (trap != 0) begin
         m_mon  = 1;
         m_stat = (eall << 3) | (user_call << 2) | ((eall != 0) << 1) | ill;
         m_pend = 0;
      end else if (m_mon) begin
         m_pend = eall;
         if (ret_req) begin
            m_mon = 0;
            m_stat = 0;
         end
      end
      if (bnd_we && mode_mon) m_bnd = bnd_wdata;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle();
      m_mon = 1; m_bnd = 'o4000; m_pend = 0; m_stat = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 mode", mode_mon, 1);
      chk("R1 status", status, 0);
      chk("R1 redir", redir_valid, 0);
      rst_n = 1'b1;
      acc_valid = 1; acc_addr = 'o3777; #1;
      chk("R1 boundary below", acc_ok, 1);
      adv();

      // R2: monitor remap of direct cells
      idle(); acc_valid = 1; acc_direct = 1; acc_addr = 'o0012; #1;
      chk("R2 remap", mem_addr, 'o7712);
      adv();
      idle(); acc_valid = 1; acc_addr = 'o0012; #1;
      chk("R2 indexed unmapped", mem_addr, 'o0012);
      adv();
      // R4: monitor may touch protected words; R10 boundary write
      idle(); acc_valid = 1; acc_addr = 'o5000; #1;
      chk("R4 monitor above", acc_ok, 1);
      adv();
      idle(); bnd_we = 1; bnd_wdata = 'o1000; adv();
      // R9: return to user
      idle(); ret_req = 1; adv();
      idle(); #1;
      chk("R9 user after ret", mode_mon, 0);
      chk("R9 status cleared", status, 0);
      // R3: no remap in user mode
      acc_valid = 1; acc_direct = 1; acc_addr = 'o0012; #1;
      chk("R3 user plain", mem_addr, 'o0012);
      adv();
      idle(); acc_valid = 1; acc_addr = 'o0777; #1;
      chk("R4 user below", acc_ok, 1);
      adv();
      // R10: user write to boundary ignored
      idle(); bnd_we = 1; bnd_wdata = 'o7000; adv();
      // R5 / R10: 0o1000 still protected
      idle(); acc_valid = 1; acc_addr = 'o1000; pc_in = 'o0345; #1;
      chk("R10 limit kept", acc_ok, 0);
      chk("R5 redirect", redir_valid, 1);
      chk("R5 target", redir_target, 'o1001);
      chk("R5 save addr", save_addr, 'o1000);
      chk("R5 save data", save_data, 'o0345);
      adv();
      idle(); #1;
      chk("R5 monitor", mode_mon, 1);
      chk("R5 status ill", status, 1);
      // R8: events held in monitor
      evt_in = 4'b0100; #1;
      chk("R8 no redirect in monitor", redir_valid, 0);
      adv();
      idle(); ret_req = 1; adv();
      idle(); #1;
      chk("R8 pending fires", redir_valid, 1);
      adv();
      idle(); #1;
      chk("R6 status event", status, 'h22);
      // R7 / R11: call together with I/O instruction
      ret_req = 1; adv();
      idle(); user_call = 1; io_instr = 1; adv();
      idle(); #1;
      chk("R7/R11 status", status, 5);
      // R9: return ignored in user
      ret_req = 1; adv();
      idle(); ret_req = 1; adv();
      idle(); #1;
      chk("R9 ret in user ignored", mode_mon, 0);
      adv();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         idle();
         acc_valid  = ($urandom_range(0, 9) < 7);
         acc_direct = ($urandom_range(0, 9) < 3);
         acc_addr   = acc_direct ? AW'($urandom_range(0, 63)) : AW'($urandom);
         io_instr   = ($urandom_range(0, 19) == 0);
         evt_in     = ($urandom_range(0, 9) == 0) ? NEVT'($urandom) : '0;
         user_call  = ($urandom_range(0, 29) == 0);
         ret_req    = ($urandom_range(0, 3) == 0);
         bnd_we     = ($urandom_range(0, 9) == 0);
         bnd_wdata  = AW'($urandom);
         pc_in      = AW'($urandom);
         adv();
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule